// File: doc/BRIEF.md
# Burst Capture Write Master

This block takes a capture stream of wide words over a ready/valid handshake and stores a capture of fixed length into memory through the write side of an AXI4 port. The memory data path is half as wide as an input word. Each word therefore leaves as two beats on the write data channel, and the beats are grouped into incrementing bursts of fixed length. The bursts start at a programmed base address and run upward one after another.

A start command arms the block. From the start edge onward, a cycle counter runs until the write response of the last burst is accepted. In the cycle after that response, the block raises a one-cycle done pulse and holds the measured count on its output until the next start. An error flag goes high and stays high when any write response carries a status other than OKAY. The capture still runs to its end in that case.

The controller has four states:
- ST_IDLE waits for start and then moves to ST_RUN.
- ST_RUN issues addresses, accepts input and sends beats. It moves to ST_DRAIN on the handshake of the final beat of the final burst.
- ST_DRAIN collects the remaining write responses. It moves to ST_DONE on the last response.
- ST_DONE lasts one cycle and then returns to ST_IDLE.

Top module: `burst_capture_writer`

## Requirements
- R1: While reset is held and after it is released, aw_valid, w_valid, s_ready, b_ready, done and err are 0 and cycle_count is 0.
- R2: Each accepted input word is sent as two beats in accepted order. The low half (bits DATA_W-1:0) goes first and the high half second, with w_strb all ones.
- R3: s_ready is 0 when the block is not in ST_RUN, when all capture words have been accepted, and while an unsent high half is held that is not being transferred in that same cycle.
- R4: Every burst carries aw_burst=2'b01 (incrementing), aw_len=BURST_LEN-1 and aw_size=log2(DATA_W/8). Burst k goes to A + k*BURST_BYTES, where A is base_addr with its low log2(BURST_BYTES) bits cleared, so no burst crosses a 4 KB boundary.
- R5: w_last is 1 exactly on the BURST_LEN-th beat of each burst.
- R6: No data beat of burst k is presented before the address of burst k has been accepted.
- R7: At most MAX_OUT bursts are outstanding, counting from address acceptance to response acceptance.
- R8: A capture issues exactly NUM_BURSTS addresses and NUM_BURSTS*BURST_LEN beats, and accepts exactly NUM_BURSTS*BURST_LEN/2 input words.
- R9: cycle_count reads 0 in the cycle after the start edge and rises by one per cycle. It ends equal to the number of clock edges from the start edge to the edge of the final response, and holds that value until the next start.
- R10: done is high for exactly the one cycle that follows the final response handshake.
- R11: A response with b_resp other than 2'b00 (OKAY) sets err from the next cycle onward. The capture still completes, and err is cleared by the next accepted start.
- R12: start is ignored outside ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a capture (taken in ST_IDLE only) |
| base_addr | input | ADDR_W | Start address, sampled with start |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted |
| s_data | input | 2*DATA_W | Input word |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Burst address |
| aw_len | output | 8 | Beats per burst minus one |
| aw_size | output | 3 | Log2 of bytes per beat |
| aw_burst | output | 2 | Burst type, incrementing |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | DATA_W | Beat data |
| w_strb | output | DATA_W/8 | Byte enables |
| w_last | output | 1 | Last beat of burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| b_resp | input | 2 | Write response status |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky bad-response flag |
| cycle_count | output | CNT_W | Measured cycles |

## Verification
The bench builds the block with NUM_BURSTS=10 and keeps the defaults of 256-bit beats, 16-beat bursts and two outstanding bursts. A capture therefore spans 5 KB. With an unaligned base it steps across a 4 KB page edge at a burst boundary, which exercises the address alignment. Slow response timing drives the outstanding limit to its cap. A second capture injects an error response and starts a third capture after it, which shows that err is sticky and is cleared by the next start. A start pulse is also applied mid-run to check that it is ignored.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } bcw_state_t;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/bcw_splitter.sv
module bcw_splitter #(
    parameter int DATA_W    = 256,
    parameter int NUM_WORDS = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic                  enable,
    input  logic                  s_valid,
    input  logic [2*DATA_W-1:0]   s_data,
    output logic                  s_ready,
    input  logic                  beat_take,
    output logic                  beat_valid,
    output logic [DATA_W-1:0]     beat_data
);
    localparam int WC_W = $clog2(NUM_WORDS + 1);

    logic [2*DATA_W-1:0] hold_q;
    logic                have_q;
    logic                upper_q;
    logic [WC_W-1:0]     taken_q;

    assign s_ready    = enable && (taken_q < WC_W'(NUM_WORDS)) &&
                        (!have_q || (upper_q && beat_take));
    assign beat_valid = have_q;
    assign beat_data  = upper_q ? hold_q[2*DATA_W-1:DATA_W] : hold_q[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            have_q  <= 1'b0;
            upper_q <= 1'b0;
            taken_q <= '0;
        end else if (arm) begin
            have_q  <= 1'b0;
            upper_q <= 1'b0;
            taken_q <= '0;
        end else begin
            if (beat_take) begin
                if (upper_q) begin
                    have_q  <= 1'b0;
                    upper_q <= 1'b0;
                end else begin
                    upper_q <= 1'b1;
                end
            end
            if (s_valid && s_ready) begin
                hold_q  <= s_data;
                have_q  <= 1'b1;
                upper_q <= 1'b0;
                taken_q <= taken_q + 1'b1;
            end
        end
    end

    // R2
    low_half_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (beat_valid && beat_data == $past(s_data[DATA_W-1:0])));

    // R3
    upper_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && upper_q && !beat_take) |-> !s_ready);
endmodule

// File: rtl/bcw_aw_issuer.sv
module bcw_aw_issuer #(
    parameter int ADDR_W      = 32,
    parameter int NUM_BURSTS  = 10,
    parameter int BURST_BYTES = 512,
    parameter int MAX_OUT     = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  arm,
    input  logic                                  enable,
    input  logic [ADDR_W-1:0]                     base_addr,
    input  logic                                  aw_ready,
    input  logic                                  b_fire,
    output logic                                  aw_valid,
    output logic [ADDR_W-1:0]                     aw_addr,
    output logic [$clog2(NUM_BURSTS+1)-1:0]       issued
);
    localparam int BC_W       = $clog2(NUM_BURSTS + 1);
    localparam int OUT_W      = $clog2(MAX_OUT + 1);
    localparam int ALIGN_BITS = $clog2(BURST_BYTES);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BURST_BYTES - 1);

    logic [ADDR_W-1:0] base_q;
    logic [BC_W-1:0]   issued_q;
    logic [OUT_W-1:0]  out_q;
    logic              aw_fire;

    assign aw_valid = enable && (issued_q < BC_W'(NUM_BURSTS)) && (out_q < OUT_W'(MAX_OUT));
    assign aw_fire  = aw_valid && aw_ready;
    assign aw_addr  = base_q + (ADDR_W'(issued_q) << ALIGN_BITS);
    assign issued   = issued_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            issued_q <= '0;
            out_q    <= '0;
        end else if (arm) begin
            base_q   <= base_addr & ~LOW_MASK;
            issued_q <= '0;
            out_q    <= '0;
        end else begin
            if (aw_fire) issued_q <= issued_q + 1'b1;
            case ({aw_fire, b_fire})
                2'b10:   out_q <= out_q + 1'b1;
                2'b01:   out_q <= out_q - 1'b1;
                default: out_q <= out_q;
            endcase
        end
    end

    // R7
    outstanding_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q <= OUT_W'(MAX_OUT));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready) |=> (!aw_valid || aw_addr == $past(aw_addr) + ADDR_W'(BURST_BYTES)));
endmodule

// File: rtl/bcw_cycle_timer.sv
module bcw_cycle_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (run)   count <= count + 1'b1;
    end
endmodule

// File: rtl/burst_capture_writer.sv
module burst_capture_writer
    import bcw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 256,
    parameter int BURST_LEN  = 16,
    parameter int NUM_BURSTS = 4,
    parameter int MAX_OUT    = 2,
    parameter int CNT_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic                  s_valid,
    output logic                  s_ready,
    input  logic [2*DATA_W-1:0]   s_data,
    output logic                  aw_valid,
    input  logic                  aw_ready,
    output logic [ADDR_W-1:0]     aw_addr,
    output logic [7:0]            aw_len,
    output logic [2:0]            aw_size,
    output logic [1:0]            aw_burst,
    output logic                  w_valid,
    input  logic                  w_ready,
    output logic [DATA_W-1:0]     w_data,
    output logic [DATA_W/8-1:0]   w_strb,
    output logic                  w_last,
    input  logic                  b_valid,
    output logic                  b_ready,
    input  logic [1:0]            b_resp,
    output logic                  done,
    output logic                  err,
    output logic [CNT_W-1:0]      cycle_count
);
    localparam int STRB_W      = DATA_W / 8;
    localparam int BURST_BYTES = BURST_LEN * STRB_W;
    localparam int NUM_WORDS   = NUM_BURSTS * BURST_LEN / 2;
    localparam int BC_W        = $clog2(NUM_BURSTS + 1);
    localparam int BT_W        = $clog2(BURST_LEN);

    bcw_state_t       state_q, state_d;
    logic             running, active, start_fire;
    logic             beat_valid, w_fire, b_fire, last_w, last_b;
    logic [DATA_W-1:0] beat_data;
    logic [BC_W-1:0]  aw_issued, w_burst_q, b_cnt_q;
    logic [BT_W-1:0]  w_beat_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)  state_d = ST_RUN;
            ST_RUN:   if (last_w) state_d = ST_DRAIN;
            ST_DRAIN: if (last_b) state_d = ST_DONE;
            ST_DONE:              state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        running = 1'b0;
        active  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RUN:   begin running = 1'b1; active = 1'b1; end
            ST_DRAIN: active = 1'b1;
            ST_DONE:  done = 1'b1;
        endcase
    end

    assign start_fire = start && (state_q == ST_IDLE);

    bcw_splitter #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) split_i (
        .clk(clk), .rst_n(rst_n), .arm(start_fire), .enable(running),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .beat_take(w_fire), .beat_valid(beat_valid), .beat_data(beat_data)
    );

    bcw_aw_issuer #(.ADDR_W(ADDR_W), .NUM_BURSTS(NUM_BURSTS),
                    .BURST_BYTES(BURST_BYTES), .MAX_OUT(MAX_OUT)) issue_i (
        .clk(clk), .rst_n(rst_n), .arm(start_fire), .enable(active),
        .base_addr(base_addr), .aw_ready(aw_ready), .b_fire(b_fire),
        .aw_valid(aw_valid), .aw_addr(aw_addr), .issued(aw_issued)
    );

    bcw_cycle_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .clear(start_fire), .run(active),
        .count(cycle_count)
    );

    assign aw_len   = 8'(BURST_LEN - 1);
    assign aw_size  = 3'($clog2(STRB_W));
    assign aw_burst = BURST_INCR;

    assign w_valid = running && beat_valid && (w_burst_q < aw_issued);
    assign w_fire  = w_valid && w_ready;
    assign w_data  = beat_data;
    assign w_strb  = '1;
    assign w_last  = (w_beat_q == BT_W'(BURST_LEN - 1));
    assign last_w  = w_fire && w_last && (w_burst_q == BC_W'(NUM_BURSTS - 1));

    assign b_ready = active;
    assign b_fire  = b_valid && b_ready;
    assign last_b  = b_fire && (b_cnt_q == BC_W'(NUM_BURSTS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_beat_q  <= '0;
            w_burst_q <= '0;
            b_cnt_q   <= '0;
            err       <= 1'b0;
        end else if (start_fire) begin
            w_beat_q  <= '0;
            w_burst_q <= '0;
            b_cnt_q   <= '0;
            err       <= 1'b0;
        end else begin
            if (w_fire) begin
                if (w_last) begin
                    w_beat_q  <= '0;
                    w_burst_q <= w_burst_q + 1'b1;
                end else begin
                    w_beat_q <= w_beat_q + 1'b1;
                end
            end
            if (b_fire) begin
                b_cnt_q <= b_cnt_q + 1'b1;
                if (b_resp != RESP_OKAY) err <= 1'b1;
            end
        end
    end

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(cycle_count));

    // R11
    err_on_bad_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready && b_resp != RESP_OKAY) |=> err);

    // R6
    data_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && w_last) |-> (aw_issued != '0));
endmodule

// File: tb/burst_capture_writer_tb_top.sv
module burst_capture_writer_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 256;
    localparam int BL     = 16;
    localparam int NB     = 10;
    localparam int NW     = NB * BL / 2;
    localparam int BBYTES = BL * DATA_W / 8;
    localparam int LIMIT  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic s_valid = 1'b0, s_ready;
    logic [2*DATA_W-1:0] s_data = '0;
    logic aw_valid, aw_ready = 1'b0;
    logic [ADDR_W-1:0] aw_addr;
    logic [7:0] aw_len;
    logic [2:0] aw_size;
    logic [1:0] aw_burst;
    logic w_valid, w_ready = 1'b0, w_last;
    logic [DATA_W-1:0] w_data;
    logic [DATA_W/8-1:0] w_strb;
    logic b_valid = 1'b0, b_ready;
    logic [1:0] b_resp = 2'b00;
    logic done, err;
    logic [31:0] cycle_count;

    always #5 clk = ~clk;

    burst_capture_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BL),
                           .NUM_BURSTS(NB), .MAX_OUT(2), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .done(done), .err(err), .cycle_count(cycle_count)
    );

    int n_checks = 0, n_fail = 0;
    int cyc = 0;
    int unsigned seed = 32'h1234_5678;

    // reference model state
    bit m_busy = 0, m_done = 0, err_exp = 0;
    int aw_cnt, w_cnt, words_acc, outstanding, b_cnt, start_cyc, cnt_exp = 0;
    logic [ADDR_W-1:0] base_al;
    logic [DATA_W-1:0] beat_q[$];
    longint aw_q[$];
    int bq[$];
    int slave_burst, slave_beat;
    logic [DATA_W-1:0] mem [longint];

    // scenario knobs
    int run_id, bad_burst, rdy_pct, src_pct, b_pct;
    bit start_req, poke;

    task automatic check(input bit ok, input string tag,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit rnd(input int pct);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'h7fff) % 100 < pct;
    endfunction

    function automatic logic [DATA_W-1:0] gen_half(input int r, input int idx, input bit hi);
        logic [31:0] w;
        w = {hi ? 8'hB1 : 8'hA0, 8'(r), 16'(idx)};
        return {8{w}};
    endfunction

    task automatic step();
        bit aw_hs, w_hs, s_hs, b_hs, st_hs, exp_sr, exp_wv, exp_awv, fin;
        logic [DATA_W-1:0] eb;
        @(negedge clk);
        cyc++;
        start     = start_req || (poke && m_busy && cyc == start_cyc + 20);
        start_req = 1'b0;
        aw_ready  = rnd(rdy_pct);
        w_ready   = rnd(rdy_pct);
        s_valid   = rnd(src_pct);
        s_data    = {gen_half(run_id, words_acc, 1'b1), gen_half(run_id, words_acc, 1'b0)};
        b_valid   = (bq.size() > 0) && rnd(b_pct);
        b_resp    = (bq.size() > 0 && bq[0] == bad_burst) ? 2'b10 : 2'b00;
        #1;
        exp_wv  = m_busy && beat_q.size() > 0 && w_cnt < aw_cnt * BL;
        check(w_valid === exp_wv, "R6 w_valid", DATA_W'(w_valid), DATA_W'(exp_wv));
        w_hs    = w_valid && w_ready;
        exp_sr  = m_busy && words_acc < NW && (beat_q.size() == 0 || (beat_q.size() == 1 && w_hs));
        check(s_ready === exp_sr, "R3 s_ready", DATA_W'(s_ready), DATA_W'(exp_sr));
        exp_awv = m_busy && aw_cnt < NB && outstanding < 2;
        check(aw_valid === exp_awv, "R7 aw_valid", DATA_W'(aw_valid), DATA_W'(exp_awv));
        check(b_ready === m_busy, "R10 b_ready", DATA_W'(b_ready), DATA_W'(m_busy));
        check(done === m_done, "R10 done", DATA_W'(done), DATA_W'(m_done));
        check(err === err_exp, "R11 err", DATA_W'(err), DATA_W'(err_exp));
        if (m_busy)
            check(cycle_count === 32'(cyc - start_cyc - 1), "R9 cycle_count running",
                  DATA_W'(cycle_count), DATA_W'(cyc - start_cyc - 1));
        else
            check(cycle_count === 32'(cnt_exp), "R9 cycle_count held",
                  DATA_W'(cycle_count), DATA_W'(cnt_exp));

        aw_hs = aw_valid && aw_ready;
        s_hs  = s_valid && s_ready;
        b_hs  = b_valid && b_ready;
        st_hs = start && !m_busy && !m_done;   // R12 start only in idle
        fin   = 1'b0;

        if (aw_hs) begin
            check(aw_addr === base_al + ADDR_W'(aw_cnt * BBYTES), "R4 aw_addr",
                  DATA_W'(aw_addr), DATA_W'(base_al + ADDR_W'(aw_cnt * BBYTES)));
            check(aw_len === 8'(BL - 1) && aw_size === 3'd5 && aw_burst === 2'b01,
                  "R4 burst fields", DATA_W'({aw_len, aw_size, aw_burst}), DATA_W'({8'(BL-1), 3'd5, 2'b01}));
            check((aw_addr & 32'hFFF) + BBYTES <= 4096, "R4 4KB boundary",
                  DATA_W'(aw_addr), DATA_W'(0));
            aw_q.push_back(longint'(aw_addr));
            aw_cnt++;
            outstanding++;
        end
        if (w_hs) begin
            eb = beat_q.pop_front();
            check(w_data === eb, "R2 beat data", w_data, eb);
            check(w_strb === '1, "R2 strobes", DATA_W'(w_strb), '1);
            check(w_last === ((w_cnt % BL) == BL - 1), "R5 w_last",
                  DATA_W'(w_last), DATA_W'((w_cnt % BL) == BL - 1));
            mem[aw_q[0] + longint'(slave_beat * (DATA_W / 8))] = w_data;
            w_cnt++;
            slave_beat++;
            if (slave_beat == BL) begin
                slave_beat = 0;
                void'(aw_q.pop_front());
                bq.push_back(slave_burst);
                slave_burst++;
            end
        end
        if (s_hs) begin
            beat_q.push_back(s_data[DATA_W-1:0]);
            beat_q.push_back(s_data[2*DATA_W-1:DATA_W]);
            words_acc++;
        end
        if (b_hs) begin
            if (b_resp != 2'b00) err_exp = 1'b1;
            void'(bq.pop_front());
            outstanding--;
            b_cnt++;
            if (b_cnt == NB) begin
                fin     = 1'b1;
                m_busy  = 1'b0;
                cnt_exp = cyc - start_cyc;
            end
        end
        m_done = fin;
        if (st_hs) begin
            m_busy = 1'b1;  err_exp = 1'b0;
            aw_cnt = 0; w_cnt = 0; words_acc = 0; outstanding = 0; b_cnt = 0;
            start_cyc = cyc;
            base_al = base_addr & ~ADDR_W'(BBYTES - 1);
            slave_burst = 0; slave_beat = 0;
            beat_q.delete(); aw_q.delete(); bq.delete();
        end
    endtask

    task automatic run_capture(input int r, input logic [ADDR_W-1:0] base, input int bad,
                               input int rp, input int sp, input int bp, input bit pk);
        int guard;
        run_id = r; bad_burst = bad; rdy_pct = rp; src_pct = sp; b_pct = bp; poke = pk;
        base_addr = base;
        mem.delete();
        start_req = 1'b1;
        guard = 0;
        step();
        while (!m_done && guard < LIMIT) begin
            step();
            guard++;
        end
        if (guard >= LIMIT)
            check(1'b0, "watchdog", DATA_W'(guard), DATA_W'(0));
        for (int i = 0; i < 3; i++) step();
        // R8 totals for this capture
        check(aw_cnt == NB && w_cnt == NB * BL && words_acc == NW, "R8 totals",
              DATA_W'({aw_cnt, w_cnt, words_acc}), DATA_W'({NB, NB * BL, NW}));
        for (int k = 0; k < NB * BL; k++) begin
            longint a = longint'(base_al) + longint'(k * (DATA_W / 8));
            logic [DATA_W-1:0] e = gen_half(r, k / 2, k[0]);
            check(mem.exists(a) && mem[a] === e, "R2 memory image",
                  mem.exists(a) ? mem[a] : '0, e);
        end
    endtask

    initial begin
        aw_cnt = 0; w_cnt = 0; words_acc = 0; outstanding = 0; b_cnt = 0; start_cyc = 0;
        base_al = '0; slave_burst = 0; slave_beat = 0;
        run_id = 0; bad_burst = -1; rdy_pct = 100; src_pct = 100; b_pct = 100;
        start_req = 0; poke = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!aw_valid && !w_valid && !s_ready && !b_ready && !done && !err && cycle_count == 0,
              "R1 reset outputs", DATA_W'({aw_valid, w_valid, s_ready, b_ready, done, err}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!aw_valid && !w_valid && !s_ready && !done && !err && cycle_count == 0,
              "R1 after reset", DATA_W'({aw_valid, w_valid, s_ready, done, err, cycle_count}), '0);
        // full-rate, unaligned base crossing a 4 KB page
        run_capture(1, 32'h0000_0F40, -1, 100, 100, 100, 1'b0);
        // stalls, slow responses hitting the outstanding cap, bad response, mid-run start (R12)
        run_capture(2, 32'h0001_2345, 3, 60, 70, 25, 1'b1);
        // err cleared by the next start (R11)
        run_capture(3, 32'h0000_0000, -1, 85, 90, 50, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule